// File: doc/BRIEF.md
# Triple Bit-Serial Adder

This block holds three independent bit-serial adder sections that run from one clock and one carry-clear input. Each section receives one bit of each of two operands per clock cycle, least-significant bit first. It produces one sum bit per cycle and keeps the carry between cycles in its own flip-flop. A per-section polarity input complements that section's sum output without touching its carry. Its typical use is in serial arithmetic pipelines, correlators and servo loops, where words arrive one bit at a time.

A build-time parameter picks the clock edge that captures the carry, rising or falling. The rest of the behaviour is the same for both settings. Pulsing the carry-clear input for one cycle before each word starts every section's word from a carry of zero.

Top module: `triple_serial_adder`

## Requirements
- R1: Each section drives `sum[i] = op_a[i] ^ op_b[i] ^ c[i] ^ invert[i]`, where `c[i]` is that section's stored carry. The sum is combinational and depends only on section i's own inputs and carry.
- R2: On each capture edge with `carry_clr` low, a section stores the majority of `op_a[i]`, `op_b[i]` and its current stored carry. That stored value becomes the carry for the next bit time.
- R3: When `carry_clr` is high at a capture edge, the stored carry of all three sections becomes 0.
- R4: While `carry_clr` is high, every section computes its sum with a carry of 0, so `sum = op_a ^ op_b ^ invert`.
- R5: `invert[i]` complements only `sum[i]`. It has no effect on any stored carry and no effect on other sections.
- R6: The parameter `CAP_EDGE` selects the carry capture edge: value 0 captures on the rising edge of `clk`, value 1 on the falling edge.
- R7: Operand words fed LSB first after a one-cycle clear produce the serial bits of (A + B) mod 2^N. Any sum bit whose `invert` was high appears complemented.
- R8: After a clear, with all operand and invert inputs at 0, every sum output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common single-phase clock |
| carry_clr | input | 1 | Active-high clear of all stored carries, sampled at the capture edge |
| op_a | input | SECTIONS | Serial bit of operand A, one per section |
| op_b | input | SECTIONS | Serial bit of operand B, one per section |
| invert | input | SECTIONS | Per-section sum polarity control |
| sum | output | SECTIONS | Serial sum bit, one per section |

## Verification
Random word pairs exercise the ordinary mix of carry generation and propagation. An all-ones operand plus one forces a carry to ripple through every bit and to stay set after the word ends, so the following clear is tested against a live carry. Per-bit random invert patterns show whether polarity leaks into the carry, which would corrupt the later bits of the word rather than just the flipped ones. Each section gets different operands, and a rising-edge and a falling-edge instance are compared against one reference on every cycle, which separates cross-section coupling from edge-selection faults.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    typedef enum logic {
        CAP_RISE = 1'b0,
        CAP_FALL = 1'b1
    } cap_edge_e;

    typedef struct packed {
        logic a;
        logic b;
        logic flip;
    } bit_in_t;

    typedef struct packed {
        logic sum;
        logic carry_nxt;
    } bit_out_t;

    function automatic logic majority3(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic bit_out_t serial_add(bit_in_t i, logic cin);
        bit_out_t o;
        o.sum       = i.a ^ i.b ^ cin ^ i.flip;
        o.carry_nxt = majority3(i.a, i.b, cin);
        return o;
    endfunction

endpackage

// File: rtl/tsa_carry_reg.sv
module tsa_carry_reg
    import tsa_pkg::*;
#(
    parameter cap_edge_e EDGE = CAP_RISE
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);

    generate
        if (EDGE == CAP_RISE) begin : g_rise
            always_ff @(posedge clk) begin
                if (clr) q <= 1'b0;
                else     q <= d;
            end
            assert_carry_cleared_R3: assert property (@(posedge clk) clr |=> (q == 1'b0));
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (clr) q <= 1'b0;
                else     q <= d;
            end
            assert_carry_cleared_fall_R3: assert property (@(negedge clk) clr |=> (q == 1'b0));
        end
    endgenerate

endmodule

// File: rtl/tsa_section.sv
module tsa_section
    import tsa_pkg::*;
#(
    parameter cap_edge_e EDGE = CAP_RISE
) (
    input  logic    clk,
    input  logic    clr,
    input  bit_in_t bits,
    output logic    sum
);

    logic     carry_q;
    logic     carry_use;
    bit_out_t res;

    assign carry_use = clr ? 1'b0 : carry_q;
    assign res       = serial_add(bits, carry_use);
    assign sum       = res.sum;

    tsa_carry_reg #(.EDGE(EDGE)) u_carry (
        .clk (clk),
        .clr (clr),
        .d   (res.carry_nxt),
        .q   (carry_q)
    );

    generate
        if (EDGE == CAP_RISE) begin : g_chk_rise
            assert_carry_majority_R2: assert property (@(posedge clk) disable iff (clr)
                !$past(clr) |-> carry_q == majority3($past(bits.a), $past(bits.b), $past(carry_q)));
        end else begin : g_chk_fall
            assert_carry_majority_fall_R2: assert property (@(negedge clk) disable iff (clr)
                !$past(clr) |-> carry_q == majority3($past(bits.a), $past(bits.b), $past(carry_q)));
        end
    endgenerate

endmodule

// File: rtl/triple_serial_adder.sv
module triple_serial_adder
    import tsa_pkg::*;
#(
    parameter int        SECTIONS = 3,
    parameter cap_edge_e CAP_EDGE = CAP_RISE
) (
    input  logic                clk,
    input  logic                carry_clr,
    input  logic [SECTIONS-1:0] op_a,
    input  logic [SECTIONS-1:0] op_b,
    input  logic [SECTIONS-1:0] invert,
    output logic [SECTIONS-1:0] sum
);

    generate
        for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
            bit_in_t sec_in;
            assign sec_in.a    = op_a[s];
            assign sec_in.b    = op_b[s];
            assign sec_in.flip = invert[s];

            tsa_section #(.EDGE(CAP_EDGE)) u_sec (
                .clk  (clk),
                .clr  (carry_clr),
                .bits (sec_in),
                .sum  (sum[s])
            );
        end
    endgenerate

    // R4: with the clear held, the outputs reflect a zero carry
    assert_clear_zero_carry_R4: assert property (@(posedge clk)
        carry_clr |-> (sum == (op_a ^ op_b ^ invert)));

endmodule

// File: tb/tb_triple_serial_adder.sv
module tb_triple_serial_adder;
    import tsa_pkg::*;

    localparam int NS    = 3;
    localparam int WBITS = 8;
    localparam int WORDS = 160;

    logic          clk = 1'b0;
    logic          clr;
    logic [NS-1:0] a, b, inv;
    logic [NS-1:0] sum_r, sum_f;

    int vectors = 0;
    int miscompares = 0;
    bit ref_c [NS];

    always #4 clk = ~clk;

    triple_serial_adder #(.SECTIONS(NS), .CAP_EDGE(CAP_RISE)) dut (
        .clk(clk), .carry_clr(clr), .op_a(a), .op_b(b), .invert(inv), .sum(sum_r));

    triple_serial_adder #(.SECTIONS(NS), .CAP_EDGE(CAP_FALL)) dut_fall (
        .clk(clk), .carry_clr(clr), .op_a(a), .op_b(b), .invert(inv), .sum(sum_f));

    task automatic check(input string req, input logic [WBITS-1:0] got, input logic [WBITS-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    // one bit time: drive after the rising edge, sample before the falling edge
    task automatic bit_step(input logic c, input logic [NS-1:0] av, input logic [NS-1:0] bv,
                            input logic [NS-1:0] iv, output logic [NS-1:0] got);
        logic [NS-1:0] exp;
        @(posedge clk);
        #2;
        clr = c; a = av; b = bv; inv = iv;
        #1;
        for (int s = 0; s < NS; s++) begin
            int cin;
            cin = c ? 0 : int'(ref_c[s]);
            exp[s] = logic'((int'(av[s]) + int'(bv[s]) + cin + int'(iv[s])) % 2);
            ref_c[s] = c ? 1'b0 : ((int'(av[s]) + int'(bv[s]) + cin) >= 2);
        end
        if (c) begin
            check("R4/R3 rise sum under clear", WBITS'(sum_r), WBITS'(exp));
            check("R4/R6 fall sum under clear", WBITS'(sum_f), WBITS'(exp));
        end else begin
            check("R1/R2 rise per-bit sum", WBITS'(sum_r), WBITS'(exp));
            check("R1/R2/R6 fall per-bit sum", WBITS'(sum_f), WBITS'(exp));
        end
        got = sum_r;
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [NS-1:0] got;
        clr = 1'b1; a = '0; b = '0; inv = '0;
        for (int s = 0; s < NS; s++) ref_c[s] = 1'b0;
        bit_step(1'b1, '0, '0, '0, got);
        bit_step(1'b1, '0, '0, '0, got);
        check("R8 reset-state sum", WBITS'(got), '0);

        for (int w = 0; w < WORDS; w++) begin
            logic [WBITS-1:0] wa [NS];
            logic [WBITS-1:0] wb [NS];
            logic [WBITS-1:0] wi [NS];
            logic [WBITS-1:0] wr [NS];
            logic [WBITS-1:0] ws [NS];
            for (int s = 0; s < NS; s++) begin
                case (w % 4)
                    0: begin wa[s] = WBITS'($urandom); wb[s] = WBITS'($urandom); wi[s] = '0; end
                    1: begin wa[s] = '1; wb[s] = WBITS'(s + 1); wi[s] = '0; end
                    2: begin wa[s] = WBITS'($urandom); wb[s] = WBITS'($urandom); wi[s] = WBITS'($urandom); end
                    default: begin wa[s] = '1; wb[s] = '1; wi[s] = (s == 1) ? '1 : '0; end
                endcase
                wr[s] = '0;
            end
            // clear bit time with live inputs (R3, R4)
            bit_step(1'b1, NS'($urandom), NS'($urandom), NS'($urandom), got);
            for (int k = 0; k < WBITS; k++) begin
                logic [NS-1:0] av, bv, iv;
                for (int s = 0; s < NS; s++) begin
                    av[s] = wa[s][k]; bv[s] = wb[s][k]; iv[s] = wi[s][k];
                end
                bit_step(1'b0, av, bv, iv, got);
                for (int s = 0; s < NS; s++) wr[s][k] = got[s];
            end
            for (int s = 0; s < NS; s++) begin
                ws[s] = WBITS'(wa[s] + wb[s]) ^ wi[s];
                if (wi[s] != '0) check("R5/R7 word with invert mask", wr[s], ws[s]);
                else             check("R7 serial word sum", wr[s], ws[s]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule